// File: doc/BRIEF.md
# Serial Transmitter with Holding Buffer

This block is the sending half of a classic asynchronous serial port. A host writes bytes into a holding stage. A mode input decides whether that stage is a single-byte register or the entry point of a 16-deep first-in first-out queue. A shifter takes one byte at a time from the holding stage and drives it onto a single line. Each character has a low start bit, 5 to 8 data bits sent least significant first, an optional parity bit and one or two high stop bits. Bit timing comes from a tick input that pulses at sixteen times the bit rate.

Two status outputs tell the host when it may write more data and when the line has gone quiet. An interrupt request tells the host that the holding stage needs refilling. In single-byte mode the request follows the hand-over of the byte to the shifter. In queue mode it follows the queue level dropping below a selectable threshold. A write or a read of the interrupt source clears a pending request.

Top module: `uart_tx_core`

## Requirements
- R1: Every serial bit, the start bit included, lasts exactly 16 cycles in which `tick16` is high. `txd` changes only on a clock edge where `tick16` is high.
- R2: A character goes out as: a start bit (0), then the data bits with bit 0 first, then the parity bit when `parity_en`=1, then the stop bits (1). The number of data bits is `word_len`+5, so `word_len` 0..3 gives 5..8 bits.
- R3: `parity_sel` sets the parity bit over the sent data bits. 0 makes the total count of ones (data plus parity) odd. 1 makes it even. 2 forces the bit to 1 and 3 forces it to 0.
- R4: `two_stop`=1 sends two stop bits and 0 sends one. When another byte is waiting, the next start bit begins on the edge that ends the last stop bit, with no idle gap.
- R5: With `fifo_mode`=1, up to 16 bytes are held and sent in write order. With `fifo_mode`=0, one byte is held. A write that arrives while the holding stage is full is discarded.
- R6: `thr_empty` is 1 exactly when no byte is waiting in the holding stage. In single-byte mode it drops after a write and returns to 1 on the first `tick16` edge that hands the byte to the shifter.
- R7: `tx_empty` is 1 only when no byte is waiting and the shifter is idle. While it is 1, `txd` is high.
- R8: `irq` is the pending request gated by `irq_en`. It is never 1 while `irq_en` is 0.
- R9: In single-byte mode the request becomes pending one cycle after the holding stage becomes empty. It also becomes pending when `irq_en` rises while the holding stage is empty.
- R10: In queue mode the request becomes pending one cycle after the queue level drops below `trig_sel`×4 bytes. `trig_sel`=0 means the level reaching zero.
- R11: A cycle with `wr_en` or `iir_rd` high clears the pending request. The clear wins over a set in the same cycle.
- R12: After reset `txd`=1, `thr_empty`=1, `tx_empty`=1 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| fifo_mode | input | 1 | 1: 16-byte queue, 0: single holding byte |
| wr_en | input | 1 | Host write strobe for the holding stage |
| wr_data | input | 8 | Byte to send |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Insert a parity bit |
| parity_sel | input | 2 | 0 odd, 1 even, 2 forced 1, 3 forced 0 |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| trig_sel | input | 2 | Queue threshold, in units of 4 bytes |
| irq_en | input | 1 | Interrupt enable |
| iir_rd | input | 1 | Host read of the interrupt source, clears the pending request |
| txd | output | 1 | Serial output, idles high |
| thr_empty | output | 1 | No byte waiting |
| tx_empty | output | 1 | No byte waiting and shifter idle |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-entry queue and 16 ticks per bit. Because the bench drives `tick16` itself, it can hold it high every cycle so that bit boundaries fall on exact cycle counts. It can also space the ticks out to show that time is counted in ticks and not in clocks, or stop them to fill the holding stage to its limit. With that control, all 40 character formats (four word lengths, five parity choices, two stop settings) are swept back to back. The same control lets the bench predict, for every threshold, the cycle at which the interrupt appears.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int FRAME_W = 12;
    localparam int DATA_W  = 8;

    typedef enum logic [1:0] {
        PAR_ODD  = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ONE  = 2'd2,
        PAR_ZERO = 2'd3
    } par_kind_e;

    // Character image, bit 0 leaves first; unused high positions stay 1 (stop/idle)
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [DATA_W-1:0] data,
        input logic [1:0]        word_len,
        input logic              parity_en,
        input par_kind_e         kind
    );
        logic [FRAME_W-1:0] img;
        logic               ones;
        logic               pbit;
        int                 nd;
        nd     = 5 + int'(word_len);
        img    = '1;
        img[0] = 1'b0;
        ones   = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nd) begin
                img[1+i] = data[i];
                ones     = ones ^ data[i];
            end
        end
        case (kind)
            PAR_ODD:  pbit = ~ones;
            PAR_EVEN: pbit = ones;
            PAR_ONE:  pbit = 1'b1;
            default:  pbit = 1'b0;
        endcase
        if (parity_en) img[1+nd] = pbit;
        return img;
    endfunction

    function automatic logic [3:0] frame_bits(
        input logic [1:0] word_len,
        input logic       parity_en,
        input logic       two_stop
    );
        return 4'd7 + 4'(word_len) + 4'(parity_en) + 4'(two_stop);
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] level,
    output logic          full
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        full    = fifo_mode ? (st_q.cnt == CW'(DEPTH)) : (st_q.cnt != '0);
        push_ok = push && !full;
        pop_ok  = pop && (st_q.cnt != '0);
        if (push_ok) st_d.wptr = step(st_q.wptr);
        if (pop_ok)  st_d.rptr = step(st_q.rptr);
        if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + CW'(1);
        else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wptr] <= push_data;
    end

    assign head  = mem[st_q.rptr];
    assign level = st_q.cnt;

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter  int TPB = 16,
    localparam int PW  = (TPB > 1) ? $clog2(TPB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              avail,
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        word_len,
    input  logic              parity_en,
    input  logic [1:0]        parity_sel,
    input  logic              two_stop,
    output logic              pop,
    output logic              txd,
    output logic              busy
);

    typedef struct packed {
        logic               busy;
        logic               txd;
        logic [FRAME_W-1:0] sh;
        logic [3:0]         left;
        logic [PW-1:0]      phase;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [FRAME_W-1:0] frame;
    logic start;

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        frame = build_frame(data, word_len, parity_en, par_kind_e'(parity_sel));
        if (tick) begin
            if (!st_q.busy) begin
                start = avail;
            end else if (st_q.phase == PW'(TPB - 1)) begin
                st_d.phase = '0;
                if (st_q.left == '0) begin
                    if (avail) begin
                        start = 1'b1;
                    end else begin
                        st_d.busy = 1'b0;
                        st_d.txd  = 1'b1;
                    end
                end else begin
                    st_d.txd  = st_q.sh[0];
                    st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
                    st_d.left = st_q.left - 4'd1;
                end
            end else begin
                st_d.phase = st_q.phase + PW'(1);
            end
        end
        if (start) begin
            st_d.busy  = 1'b1;
            st_d.txd   = frame[0];
            st_d.sh    = {1'b1, frame[FRAME_W-1:1]};
            st_d.left  = frame_bits(word_len, parity_en, two_stop) - 4'd1;
            st_d.phase = '0;
        end
        pop = start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.txd   <= 1'b1;
            st_q.sh    <= '1;
            st_q.left  <= '0;
            st_q.phase <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd  = st_q.txd;
    assign busy = st_q.busy;

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq #(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int STEP  = DEPTH / 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic [CW-1:0] level,
    input  logic [1:0]    trig_sel,
    input  logic          irq_en,
    input  logic          host_wr,
    input  logic          iir_rd,
    output logic          irq
);

    typedef struct packed {
        logic pend;
        logic cond_prev;
        logic en_prev;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [CW-1:0] thresh;
    logic cond, set, clr;

    always_comb begin
        st_d   = st_q;
        thresh = CW'(int'(trig_sel) * STEP);
        if (!fifo_mode || thresh == '0) cond = (level == '0);
        else                            cond = (level < thresh);
        set = irq_en && cond && (!st_q.cond_prev || !st_q.en_prev);
        clr = host_wr || iir_rd;
        if (clr)      st_d.pend = 1'b0;
        else if (set) st_d.pend = 1'b1;
        st_d.cond_prev = cond;
        st_d.en_prev   = irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend      <= 1'b0;
            st_q.cond_prev <= 1'b1;
            st_q.en_prev   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.pend && irq_en;

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int TPB   = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       fifo_mode,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    input  logic [1:0] parity_sel,
    input  logic       two_stop,
    input  logic [1:0] trig_sel,
    input  logic       irq_en,
    input  logic       iir_rd,
    output logic       txd,
    output logic       thr_empty,
    output logic       tx_empty,
    output logic       irq
);

    logic [CW-1:0]     fill_cnt;
    logic [DATA_W-1:0] head;
    logic              full;
    logic              pop;
    logic              busy;

    uart_tx_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .level     (fill_cnt),
        .full      (full)
    );

    uart_tx_shift #(.TPB(TPB)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .avail      (fill_cnt != '0),
        .data       (head),
        .word_len   (word_len),
        .parity_en  (parity_en),
        .parity_sel (parity_sel),
        .two_stop   (two_stop),
        .pop        (pop),
        .txd        (txd),
        .busy       (busy)
    );

    uart_tx_irq #(.DEPTH(DEPTH)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .level     (fill_cnt),
        .trig_sel  (trig_sel),
        .irq_en    (irq_en),
        .host_wr   (wr_en),
        .iir_rd    (iir_rd),
        .irq       (irq)
    );

    assign thr_empty = (fill_cnt == '0);
    assign tx_empty  = thr_empty && !busy;

endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk #(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick16,
    input logic          wr_en,
    input logic          iir_rd,
    input logic          txd,
    input logic          thr_empty,
    input logic          tx_empty,
    input logic          irq,
    input logic [CW-1:0] fill
);

    // R1
    txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16 |=> $stable(txd));

    // R7
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    // R6
    flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_empty |-> !tx_empty);

    // R11
    wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !irq);

    // R11
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rd |=> !irq);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

endmodule

bind uart_tx_core uart_tx_core_chk #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .wr_en     (wr_en),
    .iir_rd    (iir_rd),
    .txd       (txd),
    .thr_empty (thr_empty),
    .tx_empty  (tx_empty),
    .irq       (irq),
    .fill      (fill_cnt)
);

// File: tb/uart_tx_core_tb_top.sv
module uart_tx_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       fifo_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] word_len = 2'd3;
    logic       parity_en = 1'b0;
    logic [1:0] parity_sel = '0;
    logic       two_stop = 1'b0;
    logic [1:0] trig_sel = '0;
    logic       irq_en = 1'b0;
    logic       iir_rd = 1'b0;
    logic       txd, thr_empty, tx_empty, irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit tick_on = 1'b0;
    int tick_div = 1;
    int tick_cnt = 0;

    uart_tx_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .fifo_mode(fifo_mode),
        .wr_en(wr_en), .wr_data(wr_data), .word_len(word_len),
        .parity_en(parity_en), .parity_sel(parity_sel), .two_stop(two_stop),
        .trig_sel(trig_sel), .irq_en(irq_en), .iir_rd(iir_rd),
        .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty), .irq(irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!tick_on) begin
            tick16   <= 1'b0;
            tick_cnt = 0;
        end else begin
            tick16   <= (tick_cnt == 0);
            tick_cnt = (tick_cnt + 1) % tick_div;
        end
    end

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired: act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; iir_rd = 1'b0; irq_en = 1'b0; tick_on = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic int nbits_of(int nd, int pm, int st);
        return 1 + nd + ((pm != 4) ? 1 : 0) + 1 + st;
    endfunction

    // pm: 0 odd, 1 even, 2 forced 1, 3 forced 0, 4 no parity
    function automatic logic [11:0] exp_frame(logic [7:0] d, int nd, int pm);
        logic [11:0] f;
        int ones;
        f = '1;
        f[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            f[1+i] = d[i];
            ones += int'(d[i]);
        end
        if (pm == 0) f[1+nd] = (ones % 2 == 0);
        if (pm == 1) f[1+nd] = (ones % 2 == 1);
        if (pm == 2) f[1+nd] = 1'b1;
        if (pm == 3) f[1+nd] = 1'b0;
        return f;
    endfunction

    // caller sits at a negedge; samples each bit at its middle
    task automatic rx_frame(input int nb, output logic [11:0] f, output int t0);
        int guard;
        guard = 0;
        f = '1;
        while (txd !== 1'b0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        t0 = cyc;
        for (int b = 0; b < nb; b++) begin
            repeat ((b == 0) ? 8 : 16) @(negedge clk);
            f[b] = txd;
        end
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while (!tx_empty && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        logic [11:0] f, e;
        int t0, t1, nb, nd, first;
        logic [7:0] d1, d2;
        bit seen;

        repeat (2) @(negedge clk);
        // R12 reset state
        chk(txd == 1'b1, "R12 txd after reset", int'(txd), 1);
        chk(thr_empty == 1'b1, "R12 thr_empty after reset", int'(thr_empty), 1);
        chk(tx_empty == 1'b1, "R12 tx_empty after reset", int'(tx_empty), 1);
        chk(irq == 1'b0, "R12 irq after reset", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 sweep all formats, two back-to-back characters each
        fifo_mode = 1'b1;
        tick_div = 1;
        tick_on = 1'b1;
        repeat (2) @(negedge clk);
        for (int wl = 0; wl < 4; wl++) begin
            for (int pm = 0; pm < 5; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    word_len   = 2'(wl);
                    parity_en  = (pm != 4);
                    parity_sel = 2'(pm % 4);
                    two_stop   = st[0];
                    nd = 5 + wl;
                    nb = nbits_of(nd, pm, st);
                    d1 = 8'(wl * 37 + pm * 11 + st * 5 + 8'h5A);
                    d2 = d1 ^ 8'h96;
                    wr_en = 1'b1; wr_data = d1;
                    @(negedge clk);
                    wr_data = d2;
                    @(negedge clk);
                    wr_en = 1'b0;
                    rx_frame(nb, f, t0);
                    e = exp_frame(d1, nd, pm);
                    chk(f == e, "R2 R3 first character", int'(f), int'(e));
                    rx_frame(nb, f, t1);
                    e = exp_frame(d2, nd, pm);
                    chk(f == e, "R2 R3 second character", int'(f), int'(e));
                    chk(t1 - t0 == 16 * nb, "R4 R1 back-to-back spacing", t1 - t0, 16 * nb);
                    wait_idle();
                    chk(txd == 1'b1 && thr_empty, "R7 idle after sweep entry", int'(txd), 1);
                end
            end
        end

        // R6 R9 R11 single-byte flags and interrupt
        do_reset();
        fifo_mode = 1'b0; word_len = 2'd3; parity_en = 1'b0; two_stop = 1'b0;
        tick_div = 1; tick_on = 1'b1;
        repeat (2) @(negedge clk);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R9 enable while empty raises irq", int'(irq), 1);
        wr_en = 1'b1; wr_data = 8'h81;
        @(negedge clk);
        wr_en = 1'b0;
        chk(thr_empty == 1'b0, "R6 thr_empty drops after write", int'(thr_empty), 0);
        chk(irq == 1'b0, "R11 write clears irq", int'(irq), 0);
        @(negedge clk);
        chk(thr_empty == 1'b1, "R6 thr_empty set on transfer", int'(thr_empty), 1);
        chk(tx_empty == 1'b0, "R7 tx_empty low while shifting", int'(tx_empty), 0);
        chk(irq == 1'b0, "R9 irq not yet pending", int'(irq), 0);
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq one cycle after transfer", int'(irq), 1);
        iir_rd = 1'b1;
        @(negedge clk);
        iir_rd = 1'b0;
        chk(irq == 1'b0, "R11 read clears irq", int'(irq), 0);
        wait_idle();
        chk(txd == 1'b1, "R7 line high when empty", int'(txd), 1);

        // R5 R8 single-byte overflow with interrupt disabled
        do_reset();
        fifo_mode = 1'b0;
        wr_en = 1'b1; wr_data = 8'h3C;
        @(negedge clk);
        wr_data = 8'hC3;
        @(negedge clk);
        wr_en = 1'b0;
        tick_div = 1; tick_on = 1'b1;
        rx_frame(10, f, t0);
        e = exp_frame(8'h3C, 8, 4);
        chk(f == e, "R5 single byte kept, second discarded", int'(f), int'(e));
        seen = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (txd == 1'b0 || irq == 1'b1) seen = 1'b1;
        end
        chk(!seen, "R5 R8 no extra character and no irq when disabled", int'(seen), 0);

        // R5 queue holds 16, 17th discarded
        do_reset();
        fifo_mode = 1'b1;
        wr_en = 1'b1;
        for (int i = 0; i < 17; i++) begin
            wr_data = 8'(i * 13 + 7);
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk(thr_empty == 1'b0, "R6 thr_empty low with queue filled", int'(thr_empty), 0);
        tick_div = 1; tick_on = 1'b1;
        for (int i = 0; i < 16; i++) begin
            rx_frame(10, f, t0);
            e = exp_frame(8'(i * 13 + 7), 8, 4);
            chk(f == e, "R5 queue order", int'(f), int'(e));
        end
        seen = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (txd == 1'b0) seen = 1'b1;
        end
        chk(!seen && tx_empty, "R5 write to full queue discarded", int'(seen), 0);

        // R10 R11 threshold sweep
        for (int ts = 0; ts < 4; ts++) begin
            do_reset();
            fifo_mode = 1'b1; trig_sel = 2'(ts);
            wr_en = 1'b1;
            for (int i = 0; i < 16; i++) begin
                wr_data = 8'(i);
                @(negedge clk);
            end
            wr_en = 1'b0;
            irq_en = 1'b1;
            repeat (2) @(negedge clk);
            chk(irq == 1'b0, "R10 no irq with full queue", int'(irq), 0);
            tick_div = 1; tick_on = 1'b1;
            while (txd !== 1'b0) @(negedge clk);
            first = -1;
            for (int j = 0; j < 16 * 160 + 50 && first < 0; j++) begin
                if (irq) first = j;
                else @(negedge clk);
            end
            nb = (ts == 0) ? 15 : 16 - 4 * ts;
            chk(first == 160 * nb + 1, "R10 irq at threshold crossing", first, 160 * nb + 1);
            iir_rd = 1'b1;
            @(negedge clk);
            iir_rd = 1'b0;
            seen = 1'b0;
            repeat (200) begin
                @(negedge clk);
                if (irq) seen = 1'b1;
            end
            chk(!seen, "R11 cleared irq stays low below threshold", int'(seen), 0);
            wait_idle();
            irq_en = 1'b0;
        end

        // R1 sparse ticks: start bit spans 16 ticks of 4 cycles
        do_reset();
        fifo_mode = 1'b0; trig_sel = 2'd0;
        tick_div = 4; tick_on = 1'b1;
        wr_en = 1'b1; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
        while (txd !== 1'b0) @(negedge clk);
        t0 = cyc;
        while (txd !== 1'b1) @(negedge clk);
        chk(cyc - t0 == 64, "R1 bit length counts ticks", cyc - t0, 64);
        wait_idle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule